// File: doc/BRIEF.md
# Interrupt Context Save and Restore Sequencer

This block sits beside a 16-bit CPU core, between the interrupt controller and the word-wide system stack. When the controller hands over an accepted request, the sequencer writes the interrupted task's status word to the stack, followed by its return location. It then loads a new status word carrying the request's priority level, clears the serviced source's request flag, and points instruction fetch at the source's vector. On a return-from-interrupt it reads the saved words back in the opposite order and restores them to the core.

A segmentation-disable input sets the size of the frame. With segmentation disabled, the frame holds two words: the status word and the instruction pointer. With segmentation enabled, the frame holds three: the status word, the code segment pointer and the instruction pointer. If a multiply or divide is in progress when the request is accepted, the frame stores the address of that instruction instead of the next one, and a flag in the new status word is set. The stack grows downward. The block makes at most one 16-bit stack access per clock and owns the byte-addressed stack pointer.

Top module: `irq_ctx_seq`

## Requirements
- R1: After reset, busy_o is 0, no stack access is made, and sp_o equals SP_INIT (0x0080).
- R2: On entry the status word is the first word written, at sp_o-2. With seg_dis_i=1 the only other word is the return address, written at sp_o-4, for a two-word frame.
- R3: With seg_dis_i=0 the frame has three words: status word at sp_o-2, csp_i at sp_o-4, return address at sp_o-6.
- R4: The stack pointer drops by 2 before each write and rises by 2 after each read. sp_o ends at its start value minus twice the frame length after entry, and back at its start value after return.
- R5: On the vector cycle, psw_wr_o is 1 and psw_o equals the saved status word with bits [15:12] replaced by irq_lvl_i.
- R6: If mdu_busy_i was 1 at acceptance, bit 6 of the new psw_o is 1 and the saved return address is ip_cur_i. Otherwise bit 6 is 0 and the saved return address is ip_next_i.
- R7: On the vector cycle, flag_clr_o is one-hot with bit irq_src_i set. At all other times it is 0.
- R8: On the vector cycle, ip_wr_o is 1 with ip_o equal to irq_vec_i. csp_wr_o is 1 with csp_o equal to 0 only in segmented mode.
- R9: busy_o rises on the edge that accepts a request. It stays high for one cycle per pushed word plus the vector cycle, then falls.
- R10: irq_take_i and reti_i are ignored while busy_o is 1.
- R11: On return, the words are read at ascending addresses: return address, then the code segment word (segmented mode only), then the status word. A final cycle asserts psw_wr_o and ip_wr_o, plus csp_wr_o in segmented mode, with the read values.
- R12: stk_we_o and stk_re_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| irq_take_i | input | 1 | accepted interrupt request |
| irq_lvl_i | input | 4 | priority level of the request |
| irq_vec_i | input | 16 | vector address of the source |
| irq_src_i | input | 3 | index of the serviced source |
| reti_i | input | 1 | return-from-interrupt request |
| seg_dis_i | input | 1 | 1: unsegmented two-word frame |
| mdu_busy_i | input | 1 | multiply/divide in progress |
| psw_i | input | 16 | current status word |
| ip_cur_i | input | 16 | address of the current instruction |
| ip_next_i | input | 16 | address of the next instruction |
| csp_i | input | 16 | current code segment pointer |
| stk_we_o | output | 1 | stack write strobe |
| stk_re_o | output | 1 | stack read strobe |
| stk_addr_o | output | 16 | stack byte address |
| stk_wdata_o | output | 16 | stack write data |
| stk_rdata_i | input | 16 | stack read data, same cycle |
| busy_o | output | 1 | sequence in progress |
| psw_wr_o | output | 1 | load psw_o into the status word |
| psw_o | output | 16 | new status word |
| ip_wr_o | output | 1 | load ip_o into the instruction pointer |
| ip_o | output | 16 | new instruction pointer |
| csp_wr_o | output | 1 | load csp_o into the code segment pointer |
| csp_o | output | 16 | new code segment pointer |
| flag_clr_o | output | 8 | one-hot request flag clear |
| sp_o | output | 16 | stack pointer |

## Verification
The hardest case to reach is an accepted request that stays asserted throughout a busy sequence. It arrives during a segmented entry with a multiply pending, so three effects overlap. The bench holds irq_take_i high for the whole three-push entry and drops it in the same half-cycle that it sees the vector load. It then checks that exactly three writes happened and that only one vector load appeared. The two entries are nested and then unwound in reverse, so one return pass proves that a segmented frame and an unsegmented frame each restore their own words and bring the stack pointer back to its reset value.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PSH_PSW, ST_PSH_CSP, ST_PSH_IP, ST_VEC,
    ST_POP_IP, ST_POP_CSP, ST_POP_PSW, ST_RET
  } ctx_st_e;
endpackage

// File: rtl/irq_ctx_fsm.sv
module irq_ctx_fsm
  import irq_ctx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    take_i,
  input  logic    reti_i,
  input  logic    seg_dis_i,
  output ctx_st_e st_o,
  output logic    seg_dis_q_o
);
  ctx_st_e st_q, st_d;
  logic    seg_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (take_i) st_d = ST_PSH_PSW;
                  else if (reti_i) st_d = ST_POP_IP;
      ST_PSH_PSW: st_d = seg_q ? ST_PSH_IP : ST_PSH_CSP;
      ST_PSH_CSP: st_d = ST_PSH_IP;
      ST_PSH_IP:  st_d = ST_VEC;
      ST_VEC:     st_d = ST_IDLE;
      ST_POP_IP:  st_d = seg_q ? ST_POP_PSW : ST_POP_CSP;
      ST_POP_CSP: st_d = ST_POP_PSW;
      ST_POP_PSW: st_d = ST_RET;
      ST_RET:     st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      seg_q <= 1'b1;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && (take_i || reti_i)) seg_q <= seg_dis_i;
    end
  end

  assign st_o        = st_q;
  assign seg_dis_q_o = seg_q;

  // status word leads every entry frame
  p_psw_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && take_i) |=> (st_q == ST_PSH_PSW));
  // vector and restore cycles each last one clock
  p_vec_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_VEC || st_q == ST_RET) |=> (st_q == ST_IDLE));
  // segmentation choice is frozen for the whole sequence
  p_seg_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> $stable(seg_q));
endmodule

// File: rtl/irq_ctx_sp.sv
module irq_ctx_sp #(
  parameter int               AW      = 16,
  parameter logic [AW-1:0]    SP_INIT = 16'h0080
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_i,
  input  logic          inc_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] STEP = AW'(2);
  logic [AW-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_q <= SP_INIT;
    else if (dec_i) sp_q <= sp_q - STEP;
    else if (inc_i) sp_q <= sp_q + STEP;
  end

  // pre-decrement on write, post-increment on read
  assign addr_o = dec_i ? sp_q - STEP : sp_q;
  assign sp_o   = sp_q;

  p_sp_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |=> (sp_q == $past(sp_q) - STEP));
  p_sp_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> (sp_q == $past(sp_q) + STEP));
  p_one_dir_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_i && inc_i));
endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs #(
  parameter int DW        = 16,
  parameter int LVL_W     = 4,
  parameter int N_SRC     = 8,
  parameter int MULIP_BIT = 6,
  localparam int SRC_W    = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [DW-1:0]    psw_i,
  input  logic [DW-1:0]    ip_cur_i,
  input  logic [DW-1:0]    ip_next_i,
  input  logic             mdu_busy_i,
  input  logic [DW-1:0]    csp_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [DW-1:0]    vec_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic             pop_ip_i,
  input  logic             pop_csp_i,
  input  logic             pop_psw_i,
  input  logic [DW-1:0]    rdata_i,
  output logic [DW-1:0]    psw_q_o,
  output logic [DW-1:0]    csp_q_o,
  output logic [DW-1:0]    ip_q_o,
  output logic [DW-1:0]    vec_q_o,
  output logic [DW-1:0]    new_psw_o,
  output logic [N_SRC-1:0] flag_vec_o
);
  logic [DW-1:0]    psw_q, csp_q, ip_q, vec_q;
  logic [LVL_W-1:0] lvl_q;
  logic [SRC_W-1:0] src_q;
  logic             mul_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psw_q <= '0; csp_q <= '0; ip_q <= '0; vec_q <= '0;
      lvl_q <= '0; src_q <= '0; mul_q <= 1'b0;
    end else if (cap_i) begin
      psw_q <= psw_i;
      csp_q <= csp_i;
      // interrupted multiply/divide restarts from its own address
      ip_q  <= mdu_busy_i ? ip_cur_i : ip_next_i;
      mul_q <= mdu_busy_i;
      lvl_q <= lvl_i;
      vec_q <= vec_i;
      src_q <= src_i;
    end else begin
      if (pop_ip_i)  ip_q  <= rdata_i;
      if (pop_csp_i) csp_q <= rdata_i;
      if (pop_psw_i) psw_q <= rdata_i;
    end
  end

  always_comb begin
    new_psw_o = psw_q;
    new_psw_o[DW-1 -: LVL_W] = lvl_q;
    new_psw_o[MULIP_BIT]     = mul_q;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    assign flag_vec_o[g] = (src_q == SRC_W'(g));
  end

  assign psw_q_o = psw_q;
  assign csp_q_o = csp_q;
  assign ip_q_o  = ip_q;
  assign vec_q_o = vec_q;

  p_cap_pop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap_i && (pop_ip_i || pop_csp_i || pop_psw_i)));
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import irq_ctx_pkg::*;
#(
  parameter int            DW        = 16,
  parameter int            LVL_W     = 4,
  parameter int            N_SRC     = 8,
  parameter int            MULIP_BIT = 6,
  parameter logic [DW-1:0] SP_INIT   = 16'h0080,
  localparam int           SRC_W     = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_take_i,
  input  logic [LVL_W-1:0] irq_lvl_i,
  input  logic [DW-1:0]    irq_vec_i,
  input  logic [SRC_W-1:0] irq_src_i,
  input  logic             reti_i,
  input  logic             seg_dis_i,
  input  logic             mdu_busy_i,
  input  logic [DW-1:0]    psw_i,
  input  logic [DW-1:0]    ip_cur_i,
  input  logic [DW-1:0]    ip_next_i,
  input  logic [DW-1:0]    csp_i,
  output logic             stk_we_o,
  output logic             stk_re_o,
  output logic [DW-1:0]    stk_addr_o,
  output logic [DW-1:0]    stk_wdata_o,
  input  logic [DW-1:0]    stk_rdata_i,
  output logic             busy_o,
  output logic             psw_wr_o,
  output logic [DW-1:0]    psw_o,
  output logic             ip_wr_o,
  output logic [DW-1:0]    ip_o,
  output logic             csp_wr_o,
  output logic [DW-1:0]    csp_o,
  output logic [N_SRC-1:0] flag_clr_o,
  output logic [DW-1:0]    sp_o
);
  ctx_st_e       st;
  logic          seg_dis_q, is_vec, is_ret, cap;
  logic [DW-1:0] psw_q, csp_q, ip_q, vec_q, new_psw;
  logic [N_SRC-1:0] flag_vec;

  irq_ctx_fsm u_fsm (
    .clk_i, .rst_ni,
    .take_i     (irq_take_i),
    .reti_i     (reti_i),
    .seg_dis_i  (seg_dis_i),
    .st_o       (st),
    .seg_dis_q_o(seg_dis_q)
  );

  assign stk_we_o = (st == ST_PSH_PSW) || (st == ST_PSH_CSP) || (st == ST_PSH_IP);
  assign stk_re_o = (st == ST_POP_IP)  || (st == ST_POP_CSP) || (st == ST_POP_PSW);
  assign cap      = (st == ST_IDLE) && irq_take_i;
  assign is_vec   = (st == ST_VEC);
  assign is_ret   = (st == ST_RET);

  irq_ctx_sp #(.AW(DW), .SP_INIT(SP_INIT)) u_sp (
    .clk_i, .rst_ni,
    .dec_i (stk_we_o),
    .inc_i (stk_re_o),
    .sp_o  (sp_o),
    .addr_o(stk_addr_o)
  );

  irq_ctx_regs #(.DW(DW), .LVL_W(LVL_W), .N_SRC(N_SRC), .MULIP_BIT(MULIP_BIT)) u_regs (
    .clk_i, .rst_ni,
    .cap_i     (cap),
    .psw_i     (psw_i),
    .ip_cur_i  (ip_cur_i),
    .ip_next_i (ip_next_i),
    .mdu_busy_i(mdu_busy_i),
    .csp_i     (csp_i),
    .lvl_i     (irq_lvl_i),
    .vec_i     (irq_vec_i),
    .src_i     (irq_src_i),
    .pop_ip_i  (st == ST_POP_IP),
    .pop_csp_i (st == ST_POP_CSP),
    .pop_psw_i (st == ST_POP_PSW),
    .rdata_i   (stk_rdata_i),
    .psw_q_o   (psw_q),
    .csp_q_o   (csp_q),
    .ip_q_o    (ip_q),
    .vec_q_o   (vec_q),
    .new_psw_o (new_psw),
    .flag_vec_o(flag_vec)
  );

  always_comb begin
    unique case (st)
      ST_PSH_PSW: stk_wdata_o = psw_q;
      ST_PSH_CSP: stk_wdata_o = csp_q;
      ST_PSH_IP:  stk_wdata_o = ip_q;
      default:    stk_wdata_o = '0;
    endcase
  end

  assign busy_o     = (st != ST_IDLE);
  assign psw_wr_o   = is_vec || is_ret;
  assign ip_wr_o    = is_vec || is_ret;
  assign csp_wr_o   = (is_vec || is_ret) && !seg_dis_q;
  assign psw_o      = is_vec ? new_psw : psw_q;
  assign ip_o       = is_vec ? vec_q : ip_q;
  assign csp_o      = is_vec ? '0 : csp_q;
  assign flag_clr_o = is_vec ? flag_vec : '0;

  // independent access counters for frame-length checks
  logic [1:0] wr_cnt, rd_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt <= '0; rd_cnt <= '0;
    end else if (!busy_o) begin
      wr_cnt <= '0; rd_cnt <= '0;
    end else begin
      if (stk_we_o) wr_cnt <= wr_cnt + 2'd1;
      if (stk_re_o) rd_cnt <= rd_cnt + 2'd1;
    end
  end

  p_frame_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_vec |-> (wr_cnt == (seg_dis_q ? 2'd2 : 2'd3)));
  p_pop_len_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ret |-> (rd_cnt == (seg_dis_q ? 2'd2 : 2'd3)));
  p_rw_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stk_we_o && stk_re_o));
  p_flag_hot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flag_clr_o) && ((flag_clr_o != '0) -> ip_wr_o));
  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !is_vec && !is_ret) |=> busy_o);
endmodule

// File: tb/tb_irq_ctx_seq.sv
`timescale 1ns/1ps
module tb_irq_ctx_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take = 1'b0, reti = 1'b0, seg_dis = 1'b1, mdu = 1'b0;
  logic [3:0]  lvl = '0;
  logic [15:0] vec = '0, psw = '0, ip_cur = '0, ip_next = '0, csp = '0;
  logic [2:0]  src = '0;
  logic        we, re, busy, psw_wr, ip_wr, csp_wr;
  logic [15:0] addr, wdata, rdata, psw_out, ip_out, csp_out, sp;
  logic [7:0]  flag;

  always #2.5 clk = ~clk;

  irq_ctx_seq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .irq_take_i(take), .irq_lvl_i(lvl), .irq_vec_i(vec), .irq_src_i(src),
    .reti_i(reti), .seg_dis_i(seg_dis), .mdu_busy_i(mdu),
    .psw_i(psw), .ip_cur_i(ip_cur), .ip_next_i(ip_next), .csp_i(csp),
    .stk_we_o(we), .stk_re_o(re), .stk_addr_o(addr), .stk_wdata_o(wdata),
    .stk_rdata_i(rdata), .busy_o(busy),
    .psw_wr_o(psw_wr), .psw_o(psw_out), .ip_wr_o(ip_wr), .ip_o(ip_out),
    .csp_wr_o(csp_wr), .csp_o(csp_out), .flag_clr_o(flag), .sp_o(sp)
  );

  logic [15:0] mem [128];
  assign rdata = mem[addr[7:1]];

  int n_w = 0, n_r = 0, n_ev = 0, n_busy = 0, n_both = 0;
  logic [15:0] w_addr [64], w_data [64], r_addr [64];
  logic [15:0] ev_psw, ev_ip, ev_csp;
  logic        ev_pswwr, ev_cspwr;
  logic [7:0]  ev_flag;
  logic        flag_stray = 1'b0;

  always @(posedge clk) begin
    if (we) begin
      mem[addr[7:1]] <= wdata;
      w_addr[n_w % 64] = addr; w_data[n_w % 64] = wdata; n_w++;
    end
    if (re) begin r_addr[n_r % 64] = addr; n_r++; end
    if (we && re) n_both++;
    if (busy) n_busy++;
    if (flag != 8'd0 && !ip_wr) flag_stray = 1'b1;
    if (ip_wr) begin
      ev_psw = psw_out; ev_ip = ip_out; ev_csp = csp_out;
      ev_pswwr = psw_wr; ev_cspwr = csp_wr; ev_flag = flag; n_ev++;
    end
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_psw(logic [15:0] p, logic [3:0] l, logic m);
    logic [15:0] r;
    r = {l, p[11:0]};
    r[6] = m;
    return r;
  endfunction

  task automatic wait_event(input int base);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (n_ev > base) begin
        take = 1'b0; reti = 1'b0;
        break;
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 sp", {16'd0, sp}, 32'h0080);
    chk("R1 no access", {30'd0, we, re}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // hold_take keeps irq_take_i high through the whole busy window (R10)
  task automatic t_entry(input logic sd, input logic md, input logic [15:0] p,
                         input logic [3:0] l, input logic [15:0] v, input logic [2:0] s,
                         input logic [15:0] c, input logic [15:0] ic, input logic [15:0] in,
                         input bit hold_take);
    int wb, eb, bb, nf;
    logic [15:0] sp0, ret;
    wb = n_w; eb = n_ev; bb = n_busy; sp0 = sp;
    nf = sd ? 2 : 3;
    ret = md ? ic : in;
    seg_dis = sd; mdu = md; psw = p; lvl = l; vec = v; src = s;
    csp = c; ip_cur = ic; ip_next = in; take = 1'b1;
    if (!hold_take) begin
      @(negedge clk);
      take = 1'b0;
      seg_dis = ~sd; mdu = ~md;
    end
    wait_event(eb);
    chk("R9 busy low after vector", {31'd0, busy}, 32'd0);
    chk("R9 busy cycles", n_busy - bb, nf + 1);
    chk("R2 write count", n_w - wb, nf);
    chk("R2 psw first addr", {16'd0, w_addr[wb % 64]}, {16'd0, sp0 - 16'd2});
    chk("R2 psw first data", {16'd0, w_data[wb % 64]}, {16'd0, p});
    if (sd) begin
      chk("R2 ip addr", {16'd0, w_addr[(wb + 1) % 64]}, {16'd0, sp0 - 16'd4});
      chk("R6 saved ret", {16'd0, w_data[(wb + 1) % 64]}, {16'd0, ret});
    end else begin
      chk("R3 csp addr", {16'd0, w_addr[(wb + 1) % 64]}, {16'd0, sp0 - 16'd4});
      chk("R3 csp data", {16'd0, w_data[(wb + 1) % 64]}, {16'd0, c});
      chk("R3 ip addr", {16'd0, w_addr[(wb + 2) % 64]}, {16'd0, sp0 - 16'd6});
      chk("R6 saved ret", {16'd0, w_data[(wb + 2) % 64]}, {16'd0, ret});
    end
    chk("R4 sp after entry", {16'd0, sp}, {16'd0, sp0 - 16'(2 * nf)});
    chk("R5 psw load", {31'd0, ev_pswwr}, 32'd1);
    chk("R5 R6 new psw", {16'd0, ev_psw}, {16'd0, exp_psw(p, l, md)});
    chk("R8 vector", {16'd0, ev_ip}, {16'd0, v});
    chk("R8 csp load", {31'd0, ev_cspwr}, {31'd0, ~sd});
    if (!sd) chk("R8 csp cleared", {16'd0, ev_csp}, 32'd0);
    chk("R7 flag clear", {24'd0, ev_flag}, 32'd1 << s);
    chk("R10 single vector event", n_ev - eb, 1);
    repeat (3) @(negedge clk);
    chk("R10 no restart", n_w - wb, nf);
  endtask

  task automatic t_reti(input logic sd, input logic [15:0] p, input logic [15:0] c,
                        input logic [15:0] r, input logic [15:0] sp_exp);
    int rb, eb, nf;
    logic [15:0] sp0;
    rb = n_r; eb = n_ev; sp0 = sp;
    nf = sd ? 2 : 3;
    seg_dis = sd; reti = 1'b1;
    @(negedge clk);
    reti = 1'b0; seg_dis = ~sd;
    take = 1'b1;  // offered during the restore, must be ignored (R10)
    wait_event(eb);
    take = 1'b0;
    chk("R11 read count", n_r - rb, nf);
    for (int k = 0; k < nf; k++)
      chk("R11 ascending read addr", {16'd0, r_addr[(rb + k) % 64]}, {16'd0, sp0 + 16'(2 * k)});
    chk("R11 ip restored", {16'd0, ev_ip}, {16'd0, r});
    chk("R11 psw restored", {16'd0, ev_psw}, {16'd0, p});
    chk("R11 csp load", {31'd0, ev_cspwr}, {31'd0, ~sd});
    if (!sd) chk("R11 csp restored", {16'd0, ev_csp}, {16'd0, c});
    chk("R7 no flag clear on return", {24'd0, ev_flag}, 32'd0);
    chk("R4 sp after return", {16'd0, sp}, {16'd0, sp_exp});
    chk("R10 take ignored while restoring", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'h0;
    t_reset();
    // unsegmented, no multiply pending
    t_entry(1'b1, 1'b0, 16'h0A55, 4'd5, 16'h0120, 3'd3, 16'h0007, 16'h2000, 16'h2002, 1'b0);
    // nested: segmented, multiply pending, request held high while busy
    t_entry(1'b0, 1'b1, 16'h1234, 4'd9, 16'h0200, 3'd6, 16'h0003, 16'h3000, 16'h3004, 1'b1);
    t_reti(1'b0, 16'h1234, 16'h0003, 16'h3000, 16'h007C);
    t_reti(1'b1, 16'h0A55, 16'h0000, 16'h2002, 16'h0080);
    chk("R12 no simultaneous read and write", n_both, 0);
    chk("R7 no stray flag clear", {31'd0, flag_stray}, 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule